// File: doc/BRIEF.md
# DC-balanced 7:1 lane serializer

This block takes one parallel sample word per word period and sends it out over several serial lanes at seven bits per lane per word. The word carries three flag bits (sample valid, output enable, marker) in its lowest positions, five reserved bits held at zero, and the sample itself above them. The word is cut into six-bit groups. Group 0 feeds lane 0, group 1 feeds lane 1, and so on. Each lane sends its six bits and then one balance bit that keeps the lane's running disparity bounded, so an AC-coupled link carries no DC drift.

Everything runs on one clock at the serial bit rate, with a seven-slot counter. A forwarded word clock is high for the first four slots of each word and low for the last three, so its rising edge marks where a word starts. The sample resolution is programmable. A reduced-resolution sample keeps its most significant bits, and its lower bits are sent as zero.

Top module: `lane_serializer7`

## Requirements
- R1: Lane k transmits word bits 6k to 6k+5. With LANES lanes the word is 6*LANES bits wide.
- R2: Word bit 0 is valid_i, bit 1 is enable_i, bit 2 is marker_i, and bits 3 to 7 are always zero. Word bit 8+j is bit j of the truncated sample, so the sample is SAMPLE_W = 6*LANES-8 bits wide.
- R3: With an effective resolution of N bits, sample bits SAMPLE_W-1 down to SAMPLE_W-N pass unchanged and the bits below them are zero. res_i below 6 acts as 6, and res_i above SAMPLE_W acts as SAMPLE_W.
- R4: Each lane sends its group least significant bit first in slots 0 to 5 and the balance bit in slot 6. A word lasts exactly seven clocks.
- R5: Group disparity d is ones minus zeros. The group is sent inverted, with balance bit 1, when d and the lane's running disparity rd are both nonzero and of the same sign, or when d is 0 and rd is negative. Otherwise the group is sent unchanged with balance bit 0. rd then adds (ones minus zeros) of all seven sent bits and stays within -7..7.
- R6: wclk_o is 1 in slots 0 to 3 and 0 in slots 4 to 6.
- R7: The inputs present during slot 6 are latched at the end of that slot and are sent in the next seven slots. After reset is released, slot 0 begins at once, and the first seven slots send all zeros.
- R8: While rst is 1, every lane outputs 0, wclk_o is 0 and every running disparity is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_i | input | SAMPLE_W | Sample data, latched in slot 6 |
| res_i | input | RES_W | Sample resolution in bits |
| valid_i | input | 1 | Sample-valid flag, sent as word bit 0 |
| enable_i | input | 1 | Output-enable flag, sent as word bit 1 |
| marker_i | input | 1 | Marker flag, sent as word bit 2 |
| lane_o | output | LANES | Serial lane outputs |
| wclk_o | output | 1 | Forwarded word clock |

## Verification
The bench builds the block with its defaults: four lanes, a 24-bit word and a full 16-bit sample. This puts every flag, the whole reserved field and all sixteen sample bits on a lane, so truncation at both resolution limits and at both clamp cases shows at the outputs. Repeated all-ones and mixed words drive lanes through positive and negative running disparities. This reaches the zero-disparity group with a negative running disparity. A second reset in the middle of a run shows that the disparity state really clears.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int GRP    = 6;
  localparam int SLOTS  = 7;
  localparam int HI_SL  = 4;
  localparam int DISP_W = 5;
  localparam int RES_MIN = 6;

  typedef logic signed [DISP_W-1:0] disp_t;

  // ones minus zeros of a six-bit group
  function automatic disp_t grp_disp(input logic [GRP-1:0] g);
    int n;
    n = $countones(g);
    return disp_t'(2 * n - GRP);
  endfunction

  // inversion decision for one group against the running disparity
  function automatic logic want_flip(input disp_t d, input disp_t rd);
    logic same;
    same = (d[DISP_W-1] == rd[DISP_W-1]);
    return ((d != 0) && (rd != 0) && same) || ((d == 0) && rd[DISP_W-1]);
  endfunction

  // mask that keeps the top n bits of a w-bit sample
  function automatic logic [31:0] keep_mask(input int w, input int n);
    logic [31:0] ones;
    ones = (32'h1 << w) - 32'h1;
    return ones & ~((32'h1 << (w - n)) - 32'h1);
  endfunction
endpackage

// File: rtl/lsr_slot_ctr.sv
module lsr_slot_ctr
  import lsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  output logic [2:0] slot_o,
  output logic       load_o,
  output logic       frame_o
);
  logic [2:0] slot_q;

  always_ff @(posedge clk) begin
    if (rst) slot_q <= '0;
    else if (slot_q == 3'(SLOTS - 1)) slot_q <= '0;
    else slot_q <= slot_q + 3'd1;
  end

  assign slot_o  = slot_q;
  assign load_o  = (slot_q == 3'(SLOTS - 1));
  assign frame_o = (slot_q < 3'(HI_SL));

  // R4: a word lasts seven slots, then wraps to slot 0
  assert_slot_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    load_o |=> (slot_q == 3'd0));
  assert_slot_range_R4: assert property (@(posedge clk) disable iff (rst)
    slot_q <= 3'(SLOTS - 1));
endmodule

// File: rtl/lsr_word_pack.sv
module lsr_word_pack
  import lsr_pkg::*;
#(
  parameter int LANES = 4,
  localparam int WORD_W   = LANES * GRP,
  localparam int SAMPLE_W = WORD_W - 8,
  localparam int RES_W    = $clog2(SAMPLE_W + 1)
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [RES_W-1:0]    res_i,
  input  logic                valid_i,
  input  logic                enable_i,
  input  logic                marker_i,
  output logic [WORD_W-1:0]   word_o
);
  int res_eff;
  logic [31:0] mask;
  logic [SAMPLE_W-1:0] trunc;

  always_comb begin
    res_eff = int'(res_i);
    if (res_eff < RES_MIN) res_eff = RES_MIN;
    if (res_eff > SAMPLE_W) res_eff = SAMPLE_W;
    mask  = keep_mask(SAMPLE_W, res_eff);
    trunc = sample_i & mask[SAMPLE_W-1:0];
  end

  assign word_o = {trunc, 5'b00000, marker_i, enable_i, valid_i};
endmodule

// File: rtl/lsr_lane_enc.sv
module lsr_lane_enc
  import lsr_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           load_i,
  input  logic [2:0]     slot_i,
  input  logic [GRP-1:0] grp_i,
  output logic           bit_o
);
  disp_t rd_q;
  logic [SLOTS-1:0] sym_q;

  disp_t          grp_d;
  logic           flip;
  logic [GRP-1:0] tx_grp;
  disp_t          tx_disp;

  assign grp_d   = grp_disp(grp_i);
  assign flip    = want_flip(grp_d, rd_q);
  assign tx_grp  = flip ? ~grp_i : grp_i;
  assign tx_disp = grp_disp(tx_grp) + (flip ? disp_t'(1) : disp_t'(-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      sym_q <= '0;
    end else if (load_i) begin
      rd_q  <= rd_q + tx_disp;
      sym_q <= {flip, tx_grp};
    end
  end

  assign bit_o = sym_q[slot_i];

  // R5: running disparity stays bounded
  assert_disp_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_q >= disp_t'(-7)) && (rd_q <= disp_t'(7)));
  // R5: each word pulls a nonzero running disparity toward zero
  assert_disp_pull_pos_R5: assert property (@(posedge clk) disable iff (rst)
    (load_i && (rd_q > 0)) |=> (rd_q < $past(rd_q)));
  assert_disp_pull_neg_R5: assert property (@(posedge clk) disable iff (rst)
    (load_i && (rd_q < 0)) |=> (rd_q > $past(rd_q)));
endmodule

// File: rtl/lane_serializer7.sv
module lane_serializer7
  import lsr_pkg::*;
#(
  parameter int LANES = 4,
  localparam int WORD_W   = LANES * GRP,
  localparam int SAMPLE_W = WORD_W - 8,
  localparam int RES_W    = $clog2(SAMPLE_W + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [RES_W-1:0]    res_i,
  input  logic                valid_i,
  input  logic                enable_i,
  input  logic                marker_i,
  output logic [LANES-1:0]    lane_o,
  output logic                wclk_o
);
  logic [2:0]        slot;
  logic              load;
  logic              frame;
  logic [WORD_W-1:0] word;

  lsr_slot_ctr u_ctr (
    .clk(clk), .rst(rst), .slot_o(slot), .load_o(load), .frame_o(frame)
  );

  lsr_word_pack #(.LANES(LANES)) u_pack (
    .sample_i(sample_i), .res_i(res_i), .valid_i(valid_i),
    .enable_i(enable_i), .marker_i(marker_i), .word_o(word)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    lsr_lane_enc u_enc (
      .clk(clk), .rst(rst), .load_i(load), .slot_i(slot),
      .grp_i(word[k*GRP +: GRP]), .bit_o(lane_o[k])
    );
  end

  assign wclk_o = frame & ~rst;

  // R6: each load is followed by a rising word clock edge
  assert_wclk_rise_R6: assert property (@(posedge clk) disable iff (rst)
    load |=> $rose(wclk_o));
  // R6: the word clock falls only when slot 4 begins
  assert_wclk_fall_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(wclk_o) |-> (slot == 3'(HI_SL)));
  // R8: reset silences the lanes on the next cycle
  assert_rst_quiet_R8: assert property (@(posedge clk)
    rst |=> (lane_o == '0));
endmodule

// File: tb/sim_lane_serializer7.sv
module sim_lane_serializer7;
  localparam int LANES = 4;
  localparam int SW    = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [SW-1:0] sample = '0;
  logic [4:0] res = 5'd16;
  logic valid = 1'b0, enable = 1'b0, marker = 1'b0;
  logic [LANES-1:0] lane;
  logic wclk;

  int total = 0;
  int bad = 0;
  int rd [LANES];
  bit finished = 0;

  always #4 clk = ~clk;

  lane_serializer7 #(.LANES(LANES)) u0 (
    .clk(clk), .rst(rst), .sample_i(sample), .res_i(res),
    .valid_i(valid), .enable_i(enable), .marker_i(marker),
    .lane_o(lane), .wclk_o(wclk)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [23:0] model_word(input logic [15:0] s, input int r,
                                             input logic v, input logic e, input logic m);
    int n;
    logic [15:0] t;
    n = (r < 6) ? 6 : ((r > 16) ? 16 : r);
    t = s;
    for (int b = 0; b < 16 - n; b++) t[b] = 1'b0;
    return {t, 5'b0, m, e, v};
  endfunction

  // drives one word at the slot-6 negedge, checks its seven slots
  task automatic send(input string tag, input logic [15:0] s, input int r,
                      input logic v, input logic e, input logic m);
    logic [23:0] w;
    logic [6:0] sym [LANES];
    sample = s; res = 5'(r); valid = v; enable = e; marker = m;
    w = model_word(s, r, v, e, m);
    for (int k = 0; k < LANES; k++) begin
      int ones, zeros, d, dd;
      logic inv;
      logic [5:0] g;
      g = w[6*k +: 6];
      ones = 0; zeros = 0;
      for (int b = 0; b < 6; b++) if (g[b]) ones++; else zeros++;
      d = ones - zeros;
      inv = (d > 0 && rd[k] > 0) || (d < 0 && rd[k] < 0) || (d == 0 && rd[k] < 0);
      sym[k] = inv ? {1'b1, ~g} : {1'b0, g};
      dd = 0;
      for (int b = 0; b < 7; b++) dd += sym[k][b] ? 1 : -1;
      rd[k] += dd;
    end
    for (int sl = 0; sl < 7; sl++) begin
      @(posedge clk); @(negedge clk);
      for (int k = 0; k < LANES; k++)
        chk($sformatf("%s lane%0d slot%0d", tag, k, sl), int'(lane[k]), int'(sym[k][sl]));
      chk($sformatf("R6 wclk slot%0d", sl), int'(wclk), (sl < 4) ? 1 : 0);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 lanes in reset", int'(lane), 0);
    chk("R8 wclk in reset", int'(wclk), 0);
    for (int k = 0; k < LANES; k++) rd[k] = 0;
    rst = 1'b0;
    #1;
    chk("R7 idle slot0 lanes", int'(lane), 0);
    chk("R6 idle slot0 wclk", int'(wclk), 1);
    for (int sl = 1; sl < 7; sl++) begin
      @(posedge clk); @(negedge clk);
      chk($sformatf("R7 idle slot%0d lanes", sl), int'(lane), 0);
      chk($sformatf("R6 idle slot%0d wclk", sl), int'(wclk), (sl < 4) ? 1 : 0);
    end
  endtask

  task automatic t_bitmap();
    send("R1 R2 R4 valid", 16'h0000, 16, 1, 0, 0);
    send("R1 R2 R4 enable", 16'h0000, 16, 0, 1, 0);
    send("R1 R2 R4 marker", 16'h0000, 16, 0, 0, 1);
    send("R1 R2 R4 mixed", 16'hA5C3, 16, 1, 1, 1);
    send("R1 R2 R4 walk", 16'h0081, 16, 0, 1, 1);
  endtask

  task automatic t_trunc();
    send("R3 res6", 16'hFFFF, 6, 1, 0, 0);
    send("R3 res11", 16'hBEEF, 11, 0, 0, 1);
    send("R3 clamp low", 16'h7777, 3, 1, 1, 0);
    send("R3 clamp high", 16'h1234, 20, 0, 1, 0);
    send("R3 res16", 16'hFFFF, 16, 1, 1, 1);
  endtask

  task automatic t_balance();
    for (int i = 0; i < 4; i++) send("R5 ones", 16'hFFFF, 16, 1, 1, 1);
    for (int i = 0; i < 4; i++) send("R5 zeros", 16'h0000, 16, 0, 0, 0);
    send("R5 neutral", 16'h0E38, 16, 1, 1, 1);
    send("R5 neutral2", 16'h0E38, 16, 1, 1, 1);
  endtask

  task automatic t_rereset();
    for (int i = 0; i < 3; i++) send("R5 build", 16'hFFFF, 16, 1, 1, 1);
    t_reset();
    send("R8 cleared disparity", 16'hFFFF, 16, 1, 1, 1);
  endtask

  initial begin
    t_reset();
    t_bitmap();
    t_trunc();
    t_balance();
    t_rereset();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule